// File: doc/BRIEF.md
# MESI Snooping Cache Line Controller

This block keeps the coherence state of a small direct-mapped data cache attached to a shared snooping bus. Each line holds one data word, a tag and a two-bit state. The processor side issues single-word reads and writes. The block serves hits locally. On a miss, or on a write to a line it does not own outright, it issues bus commands. The snoop side watches the commands of the other caches and reacts to them. It reports sharing, supplies dirty data, forces a retry or writes back, and updates its own copy.

The line address is split into an index (the low `log2(LINES)` bits) and a tag (the remaining bits). Bus responses from the other caches come back one cycle after a command. The block drives its own snoop responses in the same way, registered one cycle after the snooped command. Arbitration between caches is assumed to happen outside this block. Snooped commands arrive only while this controller is not holding the bus.

Top module: `mesi_line_ctrl`

## Requirements
- R1: After reset every line reads Invalid (state code 00; Shared is 01, Exclusive 10, Modified 11), `cpu_req_ready` is high, and no bus command or snoop response is driven.
- R2: A read miss issues a bus read (op 00) for the requested address. The requester samples `bus_rsp_shared` in the cycle after the command. It fills the line as Shared if that input is set and as Exclusive otherwise, and returns `bus_fill_data` to the processor.
- R3: A read hit in Shared, Exclusive or Modified returns the stored word, issues no bus command and leaves the state unchanged.
- R4: A write hit on an Exclusive line stores the word and moves the line to Modified with no bus command. A write hit on a Modified line stays Modified with no bus command.
- R5: A write hit on a Shared line first issues an invalidate (op 10) for its address, then stores the word and moves the line to Modified.
- R6: A write miss issues read-with-intent-to-modify (op 01). When no retry comes back, the line takes the new tag and the written word and is marked Modified at once.
- R7: If `bus_rsp_retry` is set in the response cycle of a read-with-intent-to-modify, the requester leaves the bus and waits. It reissues the command `BACKOFF`+3 cycles after the first one, and it completes as in R6 once no retry comes back.
- R8: A snooped bus read hitting an Exclusive line raises the shared response and moves the line to Shared. A hit on a Shared line raises the shared response and keeps it Shared.
- R9: A snooped bus read hitting a Modified line raises the supply and shared responses with the stored word on `snp_data_o`, moves the line to Shared, and issues no writeback.
- R10: A snooped read-with-intent-to-modify hitting a clean (Shared or Exclusive) line invalidates it and raises no response.
- R11: A snooped read-with-intent-to-modify hitting a Modified line raises the retry response. In that same cycle it drives a writeback (op 11) carrying the line's address and word, and it invalidates the line.
- R12: A snooped invalidate hitting a Shared line moves it to Invalid. A snooped command whose tag does not match, or whose line is Invalid, changes nothing and raises no response.
- R13: A miss on a slot holding a Modified line first issues a writeback (op 11) of the victim's address and word, then issues the fill command. A clean victim is dropped with no writeback.
- R14: `cpu_req_ready` is low while a snooped command is present, while a snoop writeback is on the bus, and while a bus transaction of this controller is open. A request presented in the same cycle as a snoop is taken after the snoop and sees the line state the snoop left.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req_valid | input | 1 | Processor request present |
| cpu_req_write | input | 1 | 1 for write, 0 for read |
| cpu_req_addr | input | ADDR_W | Request address (index in low bits, tag above) |
| cpu_req_wdata | input | DATA_W | Word to write |
| cpu_req_ready | output | 1 | Request taken on a clock edge where valid and ready are both high |
| cpu_resp_valid | output | 1 | One-cycle pulse when the request completes |
| cpu_resp_rdata | output | DATA_W | Read data, or the written word for writes |
| bus_cmd_valid | output | 1 | Bus command driven this cycle |
| bus_cmd_op | output | 2 | 00 read, 01 read-with-intent-to-modify, 10 invalidate, 11 writeback |
| bus_cmd_addr | output | ADDR_W | Command address |
| bus_cmd_data | output | DATA_W | Writeback word (zero for other ops) |
| bus_rsp_shared | input | 1 | Another cache holds the line (sampled one cycle after the command) |
| bus_rsp_retry | input | 1 | Another cache holds the line modified and forces a back-off |
| bus_fill_data | input | DATA_W | Fill word from memory or a supplying cache |
| snp_valid | input | 1 | Command of another cache observed |
| snp_op | input | 2 | Observed op, same encoding as `bus_cmd_op` |
| snp_addr | input | ADDR_W | Observed address |
| snp_shared_o | output | 1 | This cache holds the snooped line |
| snp_retry_o | output | 1 | This cache holds it modified; requester must back off |
| snp_supply_o | output | 1 | This cache supplies the line instead of memory |
| snp_data_o | output | DATA_W | Supplied word |
| line_state | output | 2*LINES | State of every line, line i in bits [2i+1:2i] |

## Verification
The key overlap is a processor request and a snooped command that reach the controller in the same cycle and address the same line. The bench sets up an Exclusive line. On a single falling edge it presents a processor write and a snooped bus read for that line. It checks that the request is held off during the snoop cycle, that the snoop answers shared, and that the write is then treated as a write to a Shared line: an invalidate goes out and the line ends Modified. A second overlap comes from the snoop writeback cycle. Its bus command must never coincide with one of the requester's, and the processor side must be stalled while it is on the bus.

// File: rtl/mesi_pkg.sv
package mesi_pkg;
  typedef enum logic [1:0] {
    ST_I = 2'b00,
    ST_S = 2'b01,
    ST_E = 2'b10,
    ST_M = 2'b11
  } line_st_t;

  typedef enum logic [1:0] {
    OP_RD    = 2'b00,
    OP_RWITM = 2'b01,
    OP_INV   = 2'b10,
    OP_WB    = 2'b11
  } bus_op_t;
endpackage

// File: rtl/mesi_line_array.sv
module mesi_line_array #(
  parameter int LINES  = 4,
  parameter int IDX_W  = 2,
  parameter int TAG_W  = 6,
  parameter int DATA_W = 16
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              s_we,
  input  logic [IDX_W-1:0]                  s_idx,
  input  logic [1:0]                        s_state,
  input  logic                              r_we,
  input  logic [IDX_W-1:0]                  r_idx,
  input  logic [1:0]                        r_state,
  input  logic                              r_fill,
  input  logic                              r_dwe,
  input  logic [TAG_W-1:0]                  r_tag,
  input  logic [DATA_W-1:0]                 r_data,
  output logic [LINES-1:0][1:0]             st_o,
  output logic [LINES-1:0][TAG_W-1:0]       tag_o,
  output logic [LINES-1:0][DATA_W-1:0]      data_o
);
  logic [LINES-1:0][1:0]        st_q;
  logic [LINES-1:0][TAG_W-1:0]  tag_q;
  logic [LINES-1:0][DATA_W-1:0] data_q;

  // state bits: reset to Invalid; requester port written last so it wins
  always_ff @(posedge clk) begin
    if (rst) begin
      st_q <= '0;
    end else begin
      if (s_we) st_q[s_idx] <= s_state;
      if (r_we) st_q[r_idx] <= r_state;
    end
  end

  // tag and data carry no reset, like a plain storage array
  always_ff @(posedge clk) begin
    if (r_we && r_fill) tag_q[r_idx] <= r_tag;
    if (r_we && r_dwe)  data_q[r_idx] <= r_data;
  end

  assign st_o   = st_q;
  assign tag_o  = tag_q;
  assign data_o = data_q;

  // snoop updates and requester updates are kept apart by the stall rule
  assert_one_writer_R14: assert property (@(posedge clk) disable iff (rst)
    !(s_we && r_we));
endmodule

// File: rtl/mesi_snoop.sv
module mesi_snoop
  import mesi_pkg::*;
#(
  parameter int LINES  = 4,
  parameter int IDX_W  = 2,
  parameter int TAG_W  = 6,
  parameter int DATA_W = 16,
  parameter int ADDR_W = 8
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         snp_valid,
  input  logic [1:0]                   snp_op,
  input  logic [ADDR_W-1:0]            snp_addr,
  input  logic [LINES-1:0][1:0]        st_arr,
  input  logic [LINES-1:0][TAG_W-1:0]  tag_arr,
  input  logic [LINES-1:0][DATA_W-1:0] data_arr,
  output logic                         s_we,
  output logic [IDX_W-1:0]             s_idx,
  output logic [1:0]                   s_state,
  output logic                         rsp_shared,
  output logic                         rsp_retry,
  output logic                         rsp_supply,
  output logic [DATA_W-1:0]            rsp_data,
  output logic                         wb_valid,
  output logic [ADDR_W-1:0]            wb_addr,
  output logic [DATA_W-1:0]            wb_data
);
  logic [1:0] cur;
  logic       hit, sh, kill, sup;

  assign s_idx = snp_addr[IDX_W-1:0];
  assign cur   = st_arr[s_idx];
  assign hit   = (cur != ST_I) && (tag_arr[s_idx] == snp_addr[ADDR_W-1:IDX_W]);

  always_comb begin
    s_we    = 1'b0;
    s_state = cur;
    sh      = 1'b0;
    kill    = 1'b0;
    sup     = 1'b0;
    if (snp_valid && hit) begin
      case (snp_op)
        OP_RD: begin
          s_we    = 1'b1;
          s_state = ST_S;
          sh      = 1'b1;
          sup     = (cur == ST_M);
        end
        OP_RWITM: begin
          s_we    = 1'b1;
          s_state = ST_I;
          kill    = (cur == ST_M);
        end
        OP_INV: begin
          if (cur == ST_S) begin
            s_we    = 1'b1;
            s_state = ST_I;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_shared <= 1'b0;
      rsp_retry  <= 1'b0;
      rsp_supply <= 1'b0;
      rsp_data   <= '0;
      wb_valid   <= 1'b0;
      wb_addr    <= '0;
      wb_data    <= '0;
    end else begin
      rsp_shared <= sh;
      rsp_retry  <= kill;
      rsp_supply <= sup;
      rsp_data   <= sup ? data_arr[s_idx] : '0;
      wb_valid   <= kill;
      wb_addr    <= snp_addr;
      wb_data    <= data_arr[s_idx];
    end
  end

  assert_snoop_excl_read_R8: assert property (@(posedge clk) disable iff (rst)
    (snp_valid && snp_op == OP_RD && hit && cur == ST_E)
    |=> (rsp_shared && !rsp_supply && st_arr[$past(s_idx)] == ST_S));

  assert_snoop_dirty_read_R9: assert property (@(posedge clk) disable iff (rst)
    (snp_valid && snp_op == OP_RD && hit && cur == ST_M)
    |=> (rsp_supply && rsp_shared && !wb_valid && st_arr[$past(s_idx)] == ST_S));

  assert_snoop_clean_kill_R10: assert property (@(posedge clk) disable iff (rst)
    (snp_valid && snp_op == OP_RWITM && hit && cur != ST_M)
    |=> (!rsp_retry && !rsp_shared && st_arr[$past(s_idx)] == ST_I));

  assert_snoop_dirty_kill_R11: assert property (@(posedge clk) disable iff (rst)
    (snp_valid && snp_op == OP_RWITM && hit && cur == ST_M)
    |=> (rsp_retry && wb_valid && st_arr[$past(s_idx)] == ST_I));
endmodule

// File: rtl/mesi_requester.sv
module mesi_requester
  import mesi_pkg::*;
#(
  parameter int LINES   = 4,
  parameter int IDX_W   = 2,
  parameter int TAG_W   = 6,
  parameter int DATA_W  = 16,
  parameter int ADDR_W  = 8,
  parameter int BACKOFF = 2
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         req_valid,
  input  logic                         req_write,
  input  logic [ADDR_W-1:0]            req_addr,
  input  logic [DATA_W-1:0]            req_wdata,
  input  logic                         blocked,
  input  logic [LINES-1:0][1:0]        st_arr,
  input  logic [LINES-1:0][TAG_W-1:0]  tag_arr,
  input  logic [LINES-1:0][DATA_W-1:0] data_arr,
  input  logic                         rsp_shared,
  input  logic                         rsp_retry,
  input  logic [DATA_W-1:0]            fill_data,
  output logic                         req_ready,
  output logic                         resp_valid,
  output logic [DATA_W-1:0]            resp_rdata,
  output logic                         cmd_valid,
  output logic [1:0]                   cmd_op,
  output logic [ADDR_W-1:0]            cmd_addr,
  output logic [DATA_W-1:0]            cmd_data,
  output logic                         r_we,
  output logic [IDX_W-1:0]             r_idx,
  output logic [1:0]                   r_state,
  output logic                         r_fill,
  output logic                         r_dwe,
  output logic [TAG_W-1:0]             r_tag,
  output logic [DATA_W-1:0]            r_data
);
  localparam int CNT_W = $clog2(BACKOFF + 1) + 1;

  typedef enum logic [2:0] {R_IDLE, R_VICTIM, R_CMD, R_WAIT, R_BACKOFF} rq_t;

  rq_t               rs_q;
  logic [1:0]        op_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [CNT_W-1:0]  cnt_q;

  logic [ADDR_W-1:0] look_addr;
  logic [1:0]        cur;
  logic              hit, accept;

  assign look_addr = (rs_q == R_IDLE) ? req_addr : addr_q;
  assign r_idx     = look_addr[IDX_W-1:0];
  assign r_tag     = look_addr[ADDR_W-1:IDX_W];
  assign cur       = st_arr[r_idx];
  assign hit       = (cur != ST_I) && (tag_arr[r_idx] == r_tag);
  assign req_ready = (rs_q == R_IDLE) && !blocked;
  assign accept    = req_valid && req_ready;

  // array write port
  always_comb begin
    r_we    = 1'b0;
    r_state = cur;
    r_fill  = 1'b0;
    r_dwe   = 1'b0;
    r_data  = wdata_q;
    case (rs_q)
      R_IDLE: begin
        if (accept && req_write && hit && cur != ST_S) begin
          r_we    = 1'b1;
          r_state = ST_M;
          r_dwe   = 1'b1;
          r_data  = req_wdata;
        end
      end
      R_WAIT: begin
        if (op_q == OP_INV) begin
          r_we    = 1'b1;
          r_state = ST_M;
          r_dwe   = 1'b1;
        end else if (op_q == OP_RD) begin
          r_we    = 1'b1;
          r_fill  = 1'b1;
          r_dwe   = 1'b1;
          r_data  = fill_data;
          r_state = rsp_shared ? ST_S : ST_E;
        end else if (!rsp_retry) begin
          r_we    = 1'b1;
          r_fill  = 1'b1;
          r_dwe   = 1'b1;
          r_state = ST_M;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rs_q       <= R_IDLE;
      op_q       <= OP_RD;
      addr_q     <= '0;
      wdata_q    <= '0;
      cnt_q      <= '0;
      resp_valid <= 1'b0;
      resp_rdata <= '0;
      cmd_valid  <= 1'b0;
      cmd_op     <= OP_RD;
      cmd_addr   <= '0;
      cmd_data   <= '0;
    end else begin
      resp_valid <= 1'b0;
      cmd_valid  <= 1'b0;
      case (rs_q)
        R_IDLE: begin
          if (accept) begin
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
            if (hit && !req_write) begin
              resp_valid <= 1'b1;
              resp_rdata <= data_arr[r_idx];
            end else if (hit && cur != ST_S) begin
              resp_valid <= 1'b1;
              resp_rdata <= req_wdata;
            end else if (hit) begin
              op_q      <= OP_INV;
              cmd_valid <= 1'b1;
              cmd_op    <= OP_INV;
              cmd_addr  <= req_addr;
              cmd_data  <= '0;
              rs_q      <= R_CMD;
            end else begin
              op_q      <= req_write ? OP_RWITM : OP_RD;
              cmd_valid <= 1'b1;
              if (cur == ST_M) begin
                cmd_op   <= OP_WB;
                cmd_addr <= {tag_arr[r_idx], r_idx};
                cmd_data <= data_arr[r_idx];
                rs_q     <= R_VICTIM;
              end else begin
                cmd_op   <= req_write ? OP_RWITM : OP_RD;
                cmd_addr <= req_addr;
                cmd_data <= '0;
                rs_q     <= R_CMD;
              end
            end
          end
        end
        R_VICTIM: begin
          cmd_valid <= 1'b1;
          cmd_op    <= op_q;
          cmd_addr  <= addr_q;
          cmd_data  <= '0;
          rs_q      <= R_CMD;
        end
        R_CMD: rs_q <= R_WAIT;
        R_WAIT: begin
          if (op_q == OP_RWITM && rsp_retry) begin
            cnt_q <= CNT_W'(BACKOFF);
            rs_q  <= R_BACKOFF;
          end else begin
            resp_valid <= 1'b1;
            resp_rdata <= (op_q == OP_RD) ? fill_data : wdata_q;
            rs_q       <= R_IDLE;
          end
        end
        R_BACKOFF: begin
          if (cnt_q == '0) begin
            cmd_valid <= 1'b1;
            cmd_op    <= OP_RWITM;
            cmd_addr  <= addr_q;
            cmd_data  <= '0;
            rs_q      <= R_CMD;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        default: rs_q <= R_IDLE;
      endcase
    end
  end

  assert_read_fill_R2: assert property (@(posedge clk) disable iff (rst)
    (rs_q == R_WAIT && op_q == OP_RD)
    |=> (resp_valid && st_arr[$past(r_idx)] != ST_I && st_arr[$past(r_idx)] != ST_M));

  assert_excl_write_R4: assert property (@(posedge clk) disable iff (rst)
    (accept && req_write && hit && cur == ST_E)
    |=> (st_arr[$past(r_idx)] == ST_M && !cmd_valid && resp_valid));

  assert_fill_modified_R6: assert property (@(posedge clk) disable iff (rst)
    (rs_q == R_WAIT && op_q == OP_RWITM && !rsp_retry)
    |=> (st_arr[$past(r_idx)] == ST_M));
endmodule

// File: rtl/mesi_line_ctrl.sv
module mesi_line_ctrl
  import mesi_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 16,
  parameter int LINES   = 4,
  parameter int BACKOFF = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cpu_req_valid,
  input  logic                 cpu_req_write,
  input  logic [ADDR_W-1:0]    cpu_req_addr,
  input  logic [DATA_W-1:0]    cpu_req_wdata,
  output logic                 cpu_req_ready,
  output logic                 cpu_resp_valid,
  output logic [DATA_W-1:0]    cpu_resp_rdata,
  output logic                 bus_cmd_valid,
  output logic [1:0]           bus_cmd_op,
  output logic [ADDR_W-1:0]    bus_cmd_addr,
  output logic [DATA_W-1:0]    bus_cmd_data,
  input  logic                 bus_rsp_shared,
  input  logic                 bus_rsp_retry,
  input  logic [DATA_W-1:0]    bus_fill_data,
  input  logic                 snp_valid,
  input  logic [1:0]           snp_op,
  input  logic [ADDR_W-1:0]    snp_addr,
  output logic                 snp_shared_o,
  output logic                 snp_retry_o,
  output logic                 snp_supply_o,
  output logic [DATA_W-1:0]    snp_data_o,
  output logic [2*LINES-1:0]   line_state
);
  localparam int IDX_W = (LINES > 1) ? $clog2(LINES) : 1;
  localparam int TAG_W = ADDR_W - IDX_W;

  logic [LINES-1:0][1:0]        st_arr;
  logic [LINES-1:0][TAG_W-1:0]  tag_arr;
  logic [LINES-1:0][DATA_W-1:0] data_arr;

  logic              s_we;
  logic [IDX_W-1:0]  s_idx;
  logic [1:0]        s_state;
  logic              r_we, r_fill, r_dwe;
  logic [IDX_W-1:0]  r_idx;
  logic [1:0]        r_state;
  logic [TAG_W-1:0]  r_tag;
  logic [DATA_W-1:0] r_data;

  logic              rq_cmd_valid;
  logic [1:0]        rq_cmd_op;
  logic [ADDR_W-1:0] rq_cmd_addr;
  logic [DATA_W-1:0] rq_cmd_data;
  logic              sn_wb_valid;
  logic [ADDR_W-1:0] sn_wb_addr;
  logic [DATA_W-1:0] sn_wb_data;

  mesi_line_array #(
    .LINES(LINES), .IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)
  ) u_array (
    .clk(clk), .rst(rst),
    .s_we(s_we), .s_idx(s_idx), .s_state(s_state),
    .r_we(r_we), .r_idx(r_idx), .r_state(r_state), .r_fill(r_fill),
    .r_dwe(r_dwe), .r_tag(r_tag), .r_data(r_data),
    .st_o(st_arr), .tag_o(tag_arr), .data_o(data_arr)
  );

  mesi_snoop #(
    .LINES(LINES), .IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
  ) u_snoop (
    .clk(clk), .rst(rst),
    .snp_valid(snp_valid), .snp_op(snp_op), .snp_addr(snp_addr),
    .st_arr(st_arr), .tag_arr(tag_arr), .data_arr(data_arr),
    .s_we(s_we), .s_idx(s_idx), .s_state(s_state),
    .rsp_shared(snp_shared_o), .rsp_retry(snp_retry_o),
    .rsp_supply(snp_supply_o), .rsp_data(snp_data_o),
    .wb_valid(sn_wb_valid), .wb_addr(sn_wb_addr), .wb_data(sn_wb_data)
  );

  mesi_requester #(
    .LINES(LINES), .IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W),
    .ADDR_W(ADDR_W), .BACKOFF(BACKOFF)
  ) u_req (
    .clk(clk), .rst(rst),
    .req_valid(cpu_req_valid), .req_write(cpu_req_write),
    .req_addr(cpu_req_addr), .req_wdata(cpu_req_wdata),
    .blocked(snp_valid | sn_wb_valid),
    .st_arr(st_arr), .tag_arr(tag_arr), .data_arr(data_arr),
    .rsp_shared(bus_rsp_shared), .rsp_retry(bus_rsp_retry), .fill_data(bus_fill_data),
    .req_ready(cpu_req_ready), .resp_valid(cpu_resp_valid), .resp_rdata(cpu_resp_rdata),
    .cmd_valid(rq_cmd_valid), .cmd_op(rq_cmd_op), .cmd_addr(rq_cmd_addr),
    .cmd_data(rq_cmd_data),
    .r_we(r_we), .r_idx(r_idx), .r_state(r_state), .r_fill(r_fill),
    .r_dwe(r_dwe), .r_tag(r_tag), .r_data(r_data)
  );

  // the snoop writeback and the requester never own the bus together
  assign bus_cmd_valid = rq_cmd_valid | sn_wb_valid;
  assign bus_cmd_op    = sn_wb_valid ? OP_WB      : rq_cmd_op;
  assign bus_cmd_addr  = sn_wb_valid ? sn_wb_addr : rq_cmd_addr;
  assign bus_cmd_data  = sn_wb_valid ? sn_wb_data : rq_cmd_data;

  for (genvar i = 0; i < LINES; i++) begin : g_state_out
    assign line_state[2*i +: 2] = st_arr[i];
  end

  assert_bus_single_owner_R14: assert property (@(posedge clk) disable iff (rst)
    $onehot0({rq_cmd_valid, sn_wb_valid}));
endmodule

// File: tb/mesi_line_ctrl_test.sv
`timescale 1ns/1ps
module mesi_line_ctrl_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cpu_req_valid = 1'b0, cpu_req_write = 1'b0;
  logic [7:0]  cpu_req_addr = '0;
  logic [15:0] cpu_req_wdata = '0;
  logic        cpu_req_ready, cpu_resp_valid;
  logic [15:0] cpu_resp_rdata;
  logic        bus_cmd_valid;
  logic [1:0]  bus_cmd_op;
  logic [7:0]  bus_cmd_addr;
  logic [15:0] bus_cmd_data;
  logic        bus_rsp_shared = 1'b0, bus_rsp_retry = 1'b0;
  logic [15:0] bus_fill_data = '0;
  logic        snp_valid = 1'b0;
  logic [1:0]  snp_op = '0;
  logic [7:0]  snp_addr = '0;
  logic        snp_shared_o, snp_retry_o, snp_supply_o;
  logic [15:0] snp_data_o;
  logic [7:0]  line_state;

  int checks = 0, errors = 0, cyc = 0;
  bit done = 0;
  int n_rd = 0, n_rw = 0, n_inv = 0, n_wb = 0;
  int wb_cyc = 0, fill_cyc = 0, rw_prev = 0, rw_last = 0;
  logic [7:0]  wb_addr_seen, inv_addr_seen;
  logic [15:0] wb_data_seen;
  logic [15:0] rd;
  logic        c_sh, c_rt, c_sup, c_cv, c_rdy;
  logic [1:0]  c_cop;
  logic [7:0]  c_caddr;
  logic [15:0] c_dat, c_cdata;

  mesi_line_ctrl uut (.*);

  always #10 clk = ~clk;
  always @(posedge clk) cyc++;

  // bus monitor: counts commands of this controller, away from the edge
  always @(negedge clk) begin
    if (!rst && bus_cmd_valid) begin
      case (bus_cmd_op)
        2'b00: begin n_rd++; fill_cyc = cyc; end
        2'b01: begin n_rw++; fill_cyc = cyc; rw_prev = rw_last; rw_last = cyc; end
        2'b10: begin n_inv++; inv_addr_seen = bus_cmd_addr; end
        default: begin n_wb++; wb_cyc = cyc; wb_addr_seen = bus_cmd_addr; wb_data_seen = bus_cmd_data; end
      endcase
    end
  end

  function automatic int total();
    return n_rd + n_rw + n_inv + n_wb;
  endfunction

  function automatic logic [1:0] st(input int i);
    return line_state[2*i +: 2];
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cpu_op(input logic we, input logic [7:0] a, input logic [15:0] d);
    int n;
    @(negedge clk);
    cpu_req_valid = 1'b1; cpu_req_write = we; cpu_req_addr = a; cpu_req_wdata = d;
    while (!cpu_req_ready) @(negedge clk);
    @(posedge clk); #1 cpu_req_valid = 1'b0;
    n = 0;
    do begin @(negedge clk); n++; end while (!cpu_resp_valid && n < 60);
    rd = cpu_resp_rdata;
  endtask

  task automatic snoop(input logic [1:0] op, input logic [7:0] a);
    @(negedge clk);
    snp_valid = 1'b1; snp_op = op; snp_addr = a;
    @(posedge clk); #1 snp_valid = 1'b0;
    @(negedge clk);
    c_sh = snp_shared_o; c_rt = snp_retry_o; c_sup = snp_supply_o; c_dat = snp_data_o;
    c_cv = bus_cmd_valid; c_cop = bus_cmd_op; c_caddr = bus_cmd_addr; c_cdata = bus_cmd_data;
    c_rdy = cpu_req_ready;
  endtask

  task automatic t_reset();
    chk("R1 line_state", line_state, 8'h00);
    chk("R1 ready", cpu_req_ready, 1);
    chk("R1 bus_cmd_valid", bus_cmd_valid, 0);
    chk("R1 snoop rsp", {snp_shared_o, snp_retry_o, snp_supply_o}, 3'b000);
  endtask

  task automatic t_read_miss();
    int t0;
    t0 = n_rd;
    bus_rsp_shared = 1'b0; bus_fill_data = 16'h1111;
    cpu_op(1'b0, 8'h10, '0);
    chk("R2 excl fill data", rd, 16'h1111);
    chk("R2 excl state", st(0), 2'b10);
    chk("R2 read cmd count", n_rd - t0, 1);
    bus_rsp_shared = 1'b1; bus_fill_data = 16'h2222;
    cpu_op(1'b0, 8'h21, '0);
    chk("R2 shared fill data", rd, 16'h2222);
    chk("R2 shared state", st(1), 2'b01);
    bus_rsp_shared = 1'b0;
  endtask

  task automatic t_read_hit();
    int t0;
    t0 = total();
    cpu_op(1'b0, 8'h10, '0);
    chk("R3 hit data", rd, 16'h1111);
    chk("R3 hit state", st(0), 2'b10);
    chk("R3 no bus cmd", total() - t0, 0);
  endtask

  task automatic t_write_hit_local();
    int t0;
    t0 = total();
    cpu_op(1'b1, 8'h10, 16'hAAAA);
    chk("R4 E->M state", st(0), 2'b11);
    cpu_op(1'b1, 8'h10, 16'hBBBB);
    chk("R4 M stays M", st(0), 2'b11);
    cpu_op(1'b0, 8'h10, '0);
    chk("R4 readback", rd, 16'hBBBB);
    chk("R4 no bus cmd", total() - t0, 0);
  endtask

  task automatic t_write_hit_shared();
    int t0;
    t0 = n_inv;
    cpu_op(1'b1, 8'h21, 16'hCCCC);
    chk("R5 invalidate issued", n_inv - t0, 1);
    chk("R5 invalidate addr", inv_addr_seen, 8'h21);
    chk("R5 S->M state", st(1), 2'b11);
  endtask

  task automatic t_write_miss();
    int t0;
    t0 = n_rw;
    bus_fill_data = 16'h0F0F;
    cpu_op(1'b1, 8'h32, 16'hDDDD);
    chk("R6 rwitm issued", n_rw - t0, 1);
    chk("R6 state M", st(2), 2'b11);
    cpu_op(1'b0, 8'h32, '0);
    chk("R6 readback", rd, 16'hDDDD);
  endtask

  task automatic t_victim();
    int t0;
    t0 = n_wb;
    bus_fill_data = 16'h5555;
    cpu_op(1'b0, 8'h50, '0);
    chk("R13 victim wb count", n_wb - t0, 1);
    chk("R13 victim wb addr", wb_addr_seen, 8'h10);
    chk("R13 victim wb data", wb_data_seen, 16'hBBBB);
    chk("R13 wb before fill", (wb_cyc < fill_cyc), 1);
    chk("R13 new line data", rd, 16'h5555);
    chk("R13 new line state", st(0), 2'b10);
    t0 = n_wb;
    bus_fill_data = 16'h9999;
    cpu_op(1'b0, 8'h90, '0);
    chk("R13 clean victim no wb", n_wb - t0, 0);
    chk("R13 clean victim state", st(0), 2'b10);
  endtask

  task automatic t_retry();
    int t0;
    t0 = n_rw;
    bus_rsp_retry = 1'b1;
    fork
      cpu_op(1'b1, 8'h73, 16'h7777);
      begin
        do @(negedge clk); while (!(bus_cmd_valid && bus_cmd_op == 2'b01));
        @(posedge clk); @(posedge clk); #1 bus_rsp_retry = 1'b0;
      end
    join
    chk("R7 rwitm issued twice", n_rw - t0, 2);
    chk("R7 reissue gap", rw_last - rw_prev, 5);
    chk("R7 final state M", st(3), 2'b11);
    chk("R7 resp data", rd, 16'h7777);
  endtask

  task automatic t_snoops();
    snoop(2'b00, 8'h90);
    chk("R8 E read shared", c_sh, 1);
    chk("R8 E read no supply", c_sup, 0);
    chk("R8 E->S", st(0), 2'b01);
    snoop(2'b00, 8'h90);
    chk("R8 S read shared", c_sh, 1);
    chk("R8 S stays S", st(0), 2'b01);
    snoop(2'b00, 8'h21);
    chk("R9 supply", {c_sup, c_sh}, 2'b11);
    chk("R9 supply data", c_dat, 16'hCCCC);
    chk("R9 no writeback", c_cv, 0);
    chk("R9 M->S", st(1), 2'b01);
    snoop(2'b10, 8'h21);
    chk("R12 invalidate S->I", st(1), 2'b00);
    snoop(2'b00, 8'hA2);
    chk("R12 tag miss no rsp", {c_sh, c_rt, c_sup}, 3'b000);
    chk("R12 tag miss state", st(2), 2'b11);
    snoop(2'b01, 8'h32);
    chk("R11 retry", c_rt, 1);
    chk("R11 wb cmd", {c_cv, c_cop}, 3'b111);
    chk("R11 wb addr", c_caddr, 8'h32);
    chk("R11 wb data", c_cdata, 16'hDDDD);
    chk("R11 M->I", st(2), 2'b00);
    chk("R14 stall during snoop wb", c_rdy, 0);
    snoop(2'b01, 8'h90);
    chk("R10 S kill no rsp", {c_sh, c_rt}, 2'b00);
    chk("R10 S->I", st(0), 2'b00);
    bus_rsp_shared = 1'b0; bus_fill_data = 16'h3333;
    cpu_op(1'b0, 8'hB1, '0);
    snoop(2'b01, 8'hB1);
    chk("R10 E kill no rsp", {c_sh, c_rt}, 2'b00);
    chk("R10 E->I", st(1), 2'b00);
  endtask

  task automatic t_collision();
    int t0, n;
    bus_fill_data = 16'h4444;
    cpu_op(1'b0, 8'h40, '0);
    chk("R14 setup E", st(0), 2'b10);
    t0 = n_inv;
    @(negedge clk);
    snp_valid = 1'b1; snp_op = 2'b00; snp_addr = 8'h40;
    cpu_req_valid = 1'b1; cpu_req_write = 1'b1; cpu_req_addr = 8'h40; cpu_req_wdata = 16'hEEEE;
    #1 chk("R14 ready low on snoop", cpu_req_ready, 0);
    @(posedge clk); #1 snp_valid = 1'b0;
    @(negedge clk);
    chk("R14 snoop answered shared", snp_shared_o, 1);
    chk("R14 snoop took line to S", st(0), 2'b01);
    while (!cpu_req_ready) @(negedge clk);
    @(posedge clk); #1 cpu_req_valid = 1'b0;
    n = 0;
    do begin @(negedge clk); n++; end while (!cpu_resp_valid && n < 60);
    chk("R14 write saw S, invalidate", n_inv - t0, 1);
    chk("R14 final state M", st(0), 2'b11);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_read_miss();
    t_read_hit();
    t_write_hit_local();
    t_write_hit_shared();
    t_write_miss();
    t_victim();
    t_retry();
    t_snoops();
    t_collision();
    repeat (3) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule